// File: doc/BRIEF.md
# Sixteen-Source Peripheral Interrupt Collector

This block gathers single-cycle event pulses from sixteen peripheral sources into pending flags, gates them with a per-source enable mask and sends each source either to the standard interrupt path or to an alternate service channel. All enabled sources on the standard path are merged into one request line toward the CPU. A fixed priority picks the winner among them: a higher source number always wins.

The CPU learns the winning source in one of two ways. Software can read an index register, which returns the winner's number or a "nothing pending" code and clears that source's pending flag in the same access. The CPU can instead pulse an acknowledge input and get back a full 24-bit vector address built from a programmable base. Each source owns a 4-byte slot. The standard entry sits at offset 0 of the slot and the alternate-service entry at offset 2.

A small register bus gives access to the pending flags, the enable mask, the service-select bits, the vector base and the index register. Read data is registered and appears in the cycle after the read strobe.

Top module: `periph_irq_hub`

## Requirements
- R1: A one-cycle pulse on `srcPulse[i]` sets pending bit i. The bit stays set until it is cleared. Bus address 0 reads the pending bits, and a write to address 0 replaces them with `wrData`.
- R2: Among standard sources that are pending and enabled, the one with the highest number wins.
- R3: After reset, and whenever no source is pending, enabled and standard, a read of address 3 (the index) returns 0x0010: bit 4 set, bits 3:0 zero.
- R4: When a winner exists, an index read returns 0x000N, where N is the winner's number. Bit 4 is clear and bits 15:5 read as zero.
- R5: An index read clears the pending bit and the service-select bit of the source it returns, so the next read returns the next-highest source.
- R6: Address 1 holds the enable mask, with 1 meaning enabled, and it resets to all zeros. A pending source whose mask bit is 0 is never reported, never raises `cpuIrq`, and keeps its pending bit.
- R7: Address 2 holds the service-select bits, with 1 meaning alternate. An alternate source is never reported by the index register or by `cpuIrq`. `altReq` flags the highest enabled pending alternate source, and `altVec` is base + 4×N + 2.
- R8: `cpuIrq` is high exactly when at least one pending, enabled, standard source exists.
- R9: Pulsing `ackStrobe` makes `ackValid` high in the next cycle, with `ackVec` = base + 4×N for the winner N, or base + 0x40 when there is none. The winner's pending bit is cleared as an index read would clear it.
- R10: If an acknowledge and an index read fall in the same cycle, only one source is cleared. The acknowledge gets the vector, and the read returns the same winner without clearing it a second time.
- R11: A pulse that arrives on a source in the same cycle that source is being cleared leaves it pending.
- R12: The vector base resets to 0xFF20C0. Address 4 writes base bits 15:0 and address 5 writes base bits 23:16 from `wrData[7:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcPulse | input | 16 | Event pulses from the sources |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data, valid the cycle after `rdEn` |
| ackStrobe | input | 1 | CPU interrupt acknowledge |
| ackValid | output | 1 | Acknowledge answer valid |
| ackVec | output | 24 | Vector address returned on acknowledge |
| cpuIrq | output | 1 | Combined standard request |
| altReq | output | 1 | Some alternate source is pending and enabled |
| altVec | output | 24 | Alternate vector of the highest such source |

## Verification
The bench targets two things: the order in which simultaneous sources drain, and the collisions around a clear. With sources 10 and 3 pending, a broken priority encoder would return 3 first, and a read without a clear would return 10 forever. When an acknowledge meets a read, a design with a double clear would lose the second source. When a pulse meets a clear, a design that lets clear win would drop a fresh event. Masked and alternate sources are also checked: a design that leaks either would return their number from the index register or raise `cpuIrq`.

// File: rtl/pih_pkg.sv
package pih_pkg;

  localparam int NUM_SRC = 16;
  localparam int IDX_W   = $clog2(NUM_SRC);
  localparam int DATA_W  = 16;
  localparam int VEC_W   = 24;
  localparam int ADDR_W  = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_PEND    = 3'd0,
    REG_MASK    = 3'd1,
    REG_SEL     = 3'd2,
    REG_INDEX   = 3'd3,
    REG_BASE_LO = 3'd4,
    REG_BASE_HI = 3'd5
  } regAddr_e;

  typedef struct packed {
    logic              wrPend;
    logic              wrMask;
    logic              wrSel;
    logic              wrBaseLo;
    logic              wrBaseHi;
    logic              take;
    logic              ackTake;
    logic              rdLoad;
    logic [ADDR_W-1:0] rdAddr;
  } strobes_t;

  typedef struct packed {
    logic             found;
    logic [IDX_W-1:0] idx;
  } winner_t;

  function automatic winner_t pickHighest(input logic [NUM_SRC-1:0] vec);
    winner_t w;
    w.found = 1'b0;
    w.idx   = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (vec[i]) begin
        w.found = 1'b1;
        w.idx   = IDX_W'(i);
      end
    end
    return w;
  endfunction

endpackage

// File: rtl/pih_ctrl.sv
module pih_ctrl
  import pih_pkg::*;
(
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ackStrobe,
  output strobes_t          strobes
);

  logic idxRead;

  always_comb begin
    idxRead = rdEn && (addr == REG_INDEX);

    strobes          = '0;
    strobes.wrPend   = wrEn && (addr == REG_PEND);
    strobes.wrMask   = wrEn && (addr == REG_MASK);
    strobes.wrSel    = wrEn && (addr == REG_SEL);
    strobes.wrBaseLo = wrEn && (addr == REG_BASE_LO);
    strobes.wrBaseHi = wrEn && (addr == REG_BASE_HI);
    strobes.ackTake  = ackStrobe;
    // acknowledge owns the clear when both arrive together
    strobes.take     = ackStrobe || idxRead;
    strobes.rdLoad   = rdEn;
    strobes.rdAddr   = addr;
  end

endmodule

// File: rtl/pih_datapath.sv
module pih_datapath
  import pih_pkg::*;
#(
  parameter logic [VEC_W-1:0] RESET_BASE = 24'hFF20C0
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strobes,
  input  logic [DATA_W-1:0] wrData,
  input  logic [NUM_SRC-1:0] srcPulse,
  output logic [DATA_W-1:0] rdData,
  output logic              ackValid,
  output logic [VEC_W-1:0]  ackVec,
  output logic              cpuIrq,
  output logic              altReq,
  output logic [VEC_W-1:0]  altVec
);

  localparam int SLOT_SHIFT = 2;
  localparam logic [DATA_W-1:0] NONE_CODE = DATA_W'(1) << IDX_W;
  localparam logic [VEC_W-1:0]  NONE_SLOT = VEC_W'(NUM_SRC) << SLOT_SHIFT;

  logic [NUM_SRC-1:0] pendQ, maskQ, selQ;
  logic [VEC_W-1:0]   baseQ;
  logic [NUM_SRC-1:0] stdVec, altVecBits, clrOneHot;
  winner_t            stdWin, altWin;
  logic [DATA_W-1:0]  idxValue, rdNext;
  logic [DATA_W-1:0]  rdDataQ;
  logic               ackValidQ;
  logic [VEC_W-1:0]   ackVecQ;

  always_comb begin
    stdVec     = pendQ & maskQ & ~selQ;
    altVecBits = pendQ & maskQ & selQ;
    stdWin     = pickHighest(stdVec);
    altWin     = pickHighest(altVecBits);
    clrOneHot  = '0;
    if (strobes.take && stdWin.found) clrOneHot[stdWin.idx] = 1'b1;
    idxValue   = stdWin.found ? DATA_W'(stdWin.idx) : NONE_CODE;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rstN) begin
        pendQ[i] <= 1'b0;
        selQ[i]  <= 1'b0;
      end else begin
        // a fresh pulse beats both a bus write and a clear
        if (srcPulse[i])          pendQ[i] <= 1'b1;
        else if (strobes.wrPend)  pendQ[i] <= wrData[i];
        else if (clrOneHot[i])    pendQ[i] <= 1'b0;

        if (strobes.wrSel)        selQ[i] <= wrData[i];
        else if (clrOneHot[i])    selQ[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ <= '0;
      baseQ <= RESET_BASE;
    end else begin
      if (strobes.wrMask)   maskQ <= wrData[NUM_SRC-1:0];
      if (strobes.wrBaseLo) baseQ[15:0] <= wrData;
      if (strobes.wrBaseHi) baseQ[VEC_W-1:16] <= wrData[VEC_W-17:0];
    end
  end

  always_comb begin
    unique case (strobes.rdAddr)
      REG_PEND:    rdNext = DATA_W'(pendQ);
      REG_MASK:    rdNext = DATA_W'(maskQ);
      REG_SEL:     rdNext = DATA_W'(selQ);
      REG_INDEX:   rdNext = idxValue;
      REG_BASE_LO: rdNext = baseQ[15:0];
      REG_BASE_HI: rdNext = DATA_W'(baseQ[VEC_W-1:16]);
      default:     rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdDataQ   <= '0;
      ackValidQ <= 1'b0;
      ackVecQ   <= '0;
    end else begin
      if (strobes.rdLoad) rdDataQ <= rdNext;
      ackValidQ <= strobes.ackTake;
      if (strobes.ackTake)
        ackVecQ <= baseQ + (stdWin.found ? (VEC_W'(stdWin.idx) << SLOT_SHIFT) : NONE_SLOT);
    end
  end

  assign rdData   = rdDataQ;
  assign ackValid = ackValidQ;
  assign ackVec   = ackVecQ;
  assign cpuIrq   = stdWin.found;
  assign altReq   = altWin.found;
  assign altVec   = baseQ + (VEC_W'(altWin.idx) << SLOT_SHIFT) + VEC_W'(2);

endmodule

// File: rtl/periph_irq_hub.sv
module periph_irq_hub
  import pih_pkg::*;
#(
  parameter logic [23:0] RESET_BASE = 24'hFF20C0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] srcPulse,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [2:0]  addr,
  input  logic [15:0] wrData,
  output logic [15:0] rdData,
  input  logic        ackStrobe,
  output logic        ackValid,
  output logic [23:0] ackVec,
  output logic        cpuIrq,
  output logic        altReq,
  output logic [23:0] altVec
);

  strobes_t strobes;

  pih_ctrl u_ctrl (
    .wrEn      (wrEn),
    .rdEn      (rdEn),
    .addr      (addr),
    .ackStrobe (ackStrobe),
    .strobes   (strobes)
  );

  pih_datapath #(.RESET_BASE(RESET_BASE)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .wrData   (wrData),
    .srcPulse (srcPulse),
    .rdData   (rdData),
    .ackValid (ackValid),
    .ackVec   (ackVec),
    .cpuIrq   (cpuIrq),
    .altReq   (altReq),
    .altVec   (altVec)
  );

endmodule

// File: rtl/periph_irq_hub_chk.sv
module periph_irq_hub_chk (
  input logic        clk,
  input logic        rstN,
  input logic        rdEn,
  input logic [2:0]  addr,
  input logic [15:0] rdData,
  input logic        ackStrobe,
  input logic        ackValid,
  input logic [23:0] ackVec,
  input logic        cpuIrq,
  input logic        altReq,
  input logic [23:0] altVec
);

  // R3: an index read with no standard request returns the empty code
  p_empty_code_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == 3'd3 && !cpuIrq && !ackStrobe) |=> (rdData == 16'h0010));

  // R4: an index read with a request has bit 4 and bits 15:5 clear
  p_index_format_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == 3'd3 && cpuIrq) |=> (rdData[15:4] == 12'h000));

  // R9: the acknowledge answer comes exactly one cycle later
  p_ack_latency_r9: assert property (@(posedge clk) disable iff (!rstN)
    ackStrobe |=> ackValid);

  p_ack_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !ackStrobe |=> !ackValid);

  // R9: standard vectors sit on a slot boundary
  p_ack_slot_r9: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |-> (ackVec[1:0] == 2'b00));

  // R7: alternate vectors sit two bytes into a slot
  p_alt_offset_r7: assert property (@(posedge clk) disable iff (!rstN)
    altReq |-> (altVec[1:0] == 2'b10));

endmodule

bind periph_irq_hub periph_irq_hub_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .rdEn      (rdEn),
  .addr      (addr),
  .rdData    (rdData),
  .ackStrobe (ackStrobe),
  .ackValid  (ackValid),
  .ackVec    (ackVec),
  .cpuIrq    (cpuIrq),
  .altReq    (altReq),
  .altVec    (altVec)
);

// File: tb/test_periph_irq_hub.sv
module test_periph_irq_hub;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] srcPulse = '0;
  logic        wrEn = 1'b0, rdEn = 1'b0, ackStrobe = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        ackValid, cpuIrq, altReq;
  logic [23:0] ackVec, altVec;

  int nChecks = 0;
  int nFails  = 0;

  logic [15:0] rdExpQ[$];
  string       rdTagQ[$];
  logic [23:0] ackExpQ[$];
  string       ackTagQ[$];
  logic        lastRd = 1'b0;
  logic        done = 1'b0;

  always #4 clk = ~clk;

  periph_irq_hub i_periph_irq_hub (
    .clk(clk), .rstN(rstN), .srcPulse(srcPulse), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .ackStrobe(ackStrobe),
    .ackValid(ackValid), .ackVec(ackVec), .cpuIrq(cpuIrq), .altReq(altReq),
    .altVec(altVec)
  );

  always @(posedge clk) lastRd <= rdEn;

  // monitor: compare results against the scoreboard queues
  always @(negedge clk) begin
    if (lastRd) begin
      nChecks++;
      if (rdExpQ.size() == 0) begin
        nFails++;
        $display("FAIL unexpected read data: actual %h expected none", rdData);
      end else begin
        logic [15:0] e;
        string t;
        e = rdExpQ.pop_front();
        t = rdTagQ.pop_front();
        if (rdData !== e) begin
          nFails++;
          $display("FAIL %s: rdData actual %h expected %h", t, rdData, e);
        end
      end
    end
    if (ackValid) begin
      nChecks++;
      if (ackExpQ.size() == 0) begin
        nFails++;
        $display("FAIL unexpected ack: actual %h expected none", ackVec);
      end else begin
        logic [23:0] e;
        string t;
        e = ackExpQ.pop_front();
        t = ackTagQ.pop_front();
        if (ackVec !== e) begin
          nFails++;
          $display("FAIL %s: ackVec actual %h expected %h", t, ackVec, e);
        end
      end
    end
  end

  task automatic checkBit(input string tag, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic checkVec(input string tag, input logic [23:0] act, input logic [23:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic pulse(input logic [15:0] p);
    @(negedge clk);
    srcPulse = p;
    @(negedge clk);
    srcPulse = '0;
  endtask

  task automatic doRead(input logic [2:0] a, input logic [15:0] p,
                        input logic [15:0] exp, input string tag);
    @(negedge clk);
    addr = a; rdEn = 1'b1; srcPulse = p;
    rdExpQ.push_back(exp); rdTagQ.push_back(tag);
    @(negedge clk);
    rdEn = 1'b0; srcPulse = '0;
  endtask

  task automatic doAck(input logic withRead, input logic [23:0] exp,
                       input logic [15:0] rdExp, input string tag);
    @(negedge clk);
    ackStrobe = 1'b1;
    ackExpQ.push_back(exp); ackTagQ.push_back(tag);
    if (withRead) begin
      addr = 3'd3; rdEn = 1'b1;
      rdExpQ.push_back(rdExp); rdTagQ.push_back(tag);
    end
    @(negedge clk);
    ackStrobe = 1'b0; rdEn = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // reset state
    doRead(3'd3, '0, 16'h0010, "R3 reset index");
    doRead(3'd1, '0, 16'h0000, "R6 reset mask");
    doRead(3'd4, '0, 16'h20C0, "R12 reset base low");
    doRead(3'd5, '0, 16'h00FF, "R12 reset base high");
    checkBit("R8 reset irq", cpuIrq, 1'b0);

    // drain order
    doWrite(3'd1, 16'hFFFF);
    pulse(16'h0408);
    doRead(3'd0, '0, 16'h0408, "R1 pending latched");
    checkBit("R8 irq raised", cpuIrq, 1'b1);
    doRead(3'd3, '0, 16'h000A, "R2 R4 highest first");
    doRead(3'd3, '0, 16'h0003, "R5 next highest");
    doRead(3'd3, '0, 16'h0010, "R5 drained");
    checkBit("R8 irq dropped", cpuIrq, 1'b0);

    // masked source
    doWrite(3'd1, 16'hEFFF);
    pulse(16'h1020);
    doRead(3'd3, '0, 16'h0005, "R6 masked skipped");
    doRead(3'd0, '0, 16'h1000, "R6 masked stays pending");
    checkBit("R6 masked no irq", cpuIrq, 1'b0);
    doWrite(3'd0, 16'h0000);
    doRead(3'd0, '0, 16'h0000, "R1 pending write");

    // alternate service
    doWrite(3'd1, 16'hFFFF);
    doWrite(3'd2, 16'h8000);
    pulse(16'h8004);
    @(negedge clk);
    checkBit("R7 altReq", altReq, 1'b1);
    checkVec("R7 altVec", altVec, 24'hFF20FE);
    doRead(3'd3, '0, 16'h0002, "R7 alt not reported");
    doRead(3'd3, '0, 16'h0010, "R7 alt excluded");
    checkBit("R7 alt no irq", cpuIrq, 1'b0);
    doWrite(3'd0, 16'h0000);
    doWrite(3'd2, 16'h0000);

    // acknowledge path
    pulse(16'h0080);
    doAck(1'b0, 24'hFF20DC, '0, "R9 ack vector");
    doRead(3'd3, '0, 16'h0010, "R9 ack clears");
    doAck(1'b0, 24'hFF2100, '0, "R9 ack empty slot");

    // ack and read together
    pulse(16'h0210);
    doAck(1'b1, 24'hFF20E4, 16'h0009, "R10 ack with read");
    doRead(3'd3, '0, 16'h0004, "R10 single clear");
    doRead(3'd3, '0, 16'h0010, "R10 drained");

    // set wins over clear
    pulse(16'h0040);
    doRead(3'd3, 16'h0040, 16'h0006, "R11 read during pulse");
    doRead(3'd3, '0, 16'h0006, "R11 still pending");
    doRead(3'd3, '0, 16'h0010, "R11 drained");

    // programmable base
    doWrite(3'd4, 16'h2100);
    doWrite(3'd5, 16'h00FF);
    pulse(16'h0001);
    doAck(1'b0, 24'hFF2100, '0, "R12 base source 0");
    pulse(16'h8000);
    doAck(1'b0, 24'hFF213C, '0, "R12 base source 15");

    repeat (3) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        nChecks++;
        nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    if (rdExpQ.size() != 0 || ackExpQ.size() != 0) begin
      nChecks++;
      nFails++;
      $display("FAIL scoreboard: actual %0d items left expected 0",
               rdExpQ.size() + ackExpQ.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule